// File: doc/BRIEF.md
# Test Pattern Vector Sequencer

This block steps through a stored test program for a cycle-based tester. Each memory word is either a vector, carrying one waveform character per pin, or a control instruction: multi-vector loop, loop end marker, timing-table select or stop. Every vector is sent to the pin formatters with a one-cycle strobe. A loop whose body is one vector becomes a repeat. The vector is read once and strobed on consecutive cycles. A burst runs a list of patterns, each given by its start address.

A vector can carry a label. After a labelled vector the sequencer freezes the pins and raises a request, so an external instrument can measure output levels, tri-state leakage or supply current. It continues only when it receives a resume pulse. Multi-vector loops nest on a small stack of return addresses and counts. Too deep a nesting aborts the burst with an error flag.

The program memory is an external synchronous RAM with one cycle of read latency. It is read through `mem_rd`/`mem_addr`/`mem_data`. Each instruction takes a fetch cycle and a decode cycle.

Top module: `vec_seq`

## Requirements
- R1: After reset, `busy`, `vec_stb`, `measure_req`, `done`, `err`, `mem_rd`, `pin_wfc` and `tbl_sel` are all zero.
- R2: A word whose top three bits are 0 (plain) or 1 (labelled) is a vector. Its low NPINS*WFC_W bits appear on `pin_wfc` while `vec_stb` is high for one cycle. Vectors come out in program order, and two fetched vectors never strobe on adjacent cycles.
- R3: A loop (opcode 2) whose end address equals its own address plus 2 has a one-vector body. That vector strobes `count` times on consecutive cycles with no memory read in between. Execution then continues past the end marker.
- R4: A loop word (opcode 2) holds its count in bits [CNT_W-1:0] and the address of its end marker (opcode 3) in bits [CNT_W +: ADDR_W]. The body between them runs `count` times.
- R5: A loop with count 0 runs none of its body and continues at the end address plus one.
- R6: A labelled vector raises `measure_req` in the cycle where its strobe is seen. For a repeat this happens only after the final copy. While halted, there is no strobe and `pin_wfc`/`tbl_sel` stay unchanged. A `resume` pulse continues with the next instruction.
- R7: A table-select word (opcode 4) sets `tbl_sel` from its low TBL_W bits for every vector after it.
- R8: Up to DEPTH multi-vector loops can nest. Starting one more sets `err`, returns to idle (`busy` low) and gives no `done`.
- R9: A stop word (opcode 5) jumps to the next start address in `pat_base`. At pattern index `pat_last` it instead pulses `done` for one cycle and drops `busy`.
- R10: A `start` pulse while idle clears `err` and `tbl_sel`. On the next cycle it reads the start address of pattern 0 (`mem_rd` high, `mem_addr` = entry 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a burst (idle only) |
| pat_last | input | $clog2(NPAT) | Index of the last pattern in the burst |
| pat_base | input | NPAT*ADDR_W | Start address of each pattern, entry 0 in the low bits |
| resume | input | 1 | Continue after a measurement halt |
| mem_rd | output | 1 | Program memory read enable |
| mem_addr | output | ADDR_W | Program memory address |
| mem_data | input | NPINS*WFC_W+3 | Read data, one cycle after the read |
| pin_wfc | output | NPINS*WFC_W | Waveform characters of the current vector |
| vec_stb | output | 1 | One strobe per applied vector |
| tbl_sel | output | TBL_W | Active timing table |
| measure_req | output | 1 | Halted at a labelled vector |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at the end of the burst |
| err | output | 1 | Loop stack overflow, sticky until the next start |

## Verification
The embedded properties check four things on every cycle. While halted, pins and table stay frozen and no strobe appears. Back-to-back strobes always repeat the same vector with no memory read in between. `done` lasts one cycle. An error always leaves the block idle. Only the bench's programs can show that the vector order is right, including nested and zero-count loops and table changes. The same applies to the label halting only after the last copy of a repeat, to the hand-over between patterns of a burst, and to the exact depth at which the stack overflows. The bench compares each of these with an instruction-level model of the program.

// File: rtl/vec_seq.sv
module vec_seq #(
  parameter int NPINS  = 8,
  parameter int WFC_W  = 4,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int DEPTH  = 4,
  parameter int NPAT   = 4,
  parameter int TBL_W  = 2,
  localparam int PW    = NPINS * WFC_W,
  localparam int IW    = PW + 3,
  localparam int PI_W  = $clog2(NPAT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [PI_W-1:0]        pat_last,
  input  logic [NPAT*ADDR_W-1:0] pat_base,
  input  logic                   resume,
  output logic                   mem_rd,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic [IW-1:0]          mem_data,
  output logic [PW-1:0]          pin_wfc,
  output logic                   vec_stb,
  output logic [TBL_W-1:0]       tbl_sel,
  output logic                   measure_req,
  output logic                   busy,
  output logic                   done,
  output logic                   err
);
  localparam int SP_W = $clog2(DEPTH + 1);
  localparam int ST_W = $clog2(DEPTH);
  localparam logic [2:0] OP_VEC = 3'd0, OP_LVEC = 3'd1, OP_LOOP = 3'd2,
                         OP_ENDL = 3'd3, OP_TBL = 3'd4, OP_STOP = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DEC, S_REP, S_HALT} state_t;
  state_t state;

  logic [ADDR_W-1:0] pc;
  logic [PI_W-1:0]   pidx;
  logic [SP_W-1:0]   sp;
  logic [ADDR_W-1:0] st_beg [DEPTH];
  logic [CNT_W-1:0]  st_cnt [DEPTH];
  logic [CNT_W-1:0]  reps;
  logic              rskip, lab;

  wire [2:0]        op      = mem_data[IW-1 -: 3];
  wire [CNT_W-1:0]  cnt     = mem_data[CNT_W-1:0];
  wire [ADDR_W-1:0] endaddr = mem_data[CNT_W +: ADDR_W];
  wire [ST_W-1:0]   top     = ST_W'(sp - 1'b1);
  wire [PI_W-1:0]   nidx    = pidx + 1'b1;
  wire [ADDR_W-1:0] vec_nxt = pc + (rskip ? ADDR_W'(2) : ADDR_W'(1));

  assign mem_rd      = (state == S_FETCH);
  assign mem_addr    = pc;
  assign busy        = (state != S_IDLE);
  assign measure_req = (state == S_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pc      <= '0;
      pidx    <= '0;
      sp      <= '0;
      reps    <= '0;
      rskip   <= 1'b0;
      lab     <= 1'b0;
      pin_wfc <= '0;
      vec_stb <= 1'b0;
      tbl_sel <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        st_beg[i] <= '0;
        st_cnt[i] <= '0;
      end
    end else begin
      vec_stb <= 1'b0;
      done    <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          pc      <= pat_base[ADDR_W-1:0];
          pidx    <= '0;
          sp      <= '0;
          reps    <= '0;
          rskip   <= 1'b0;
          err     <= 1'b0;
          tbl_sel <= '0;
          state   <= S_FETCH;
        end
        S_FETCH: state <= S_DEC;
        S_DEC: begin
          case (op)
            OP_VEC, OP_LVEC: begin
              pin_wfc <= mem_data[PW-1:0];
              vec_stb <= 1'b1;
              lab     <= (op == OP_LVEC);
              if (reps > 1) begin
                reps  <= reps - 1'b1;
                state <= S_REP;
              end else begin
                pc    <= vec_nxt;
                reps  <= '0;
                rskip <= 1'b0;
                state <= (op == OP_LVEC) ? S_HALT : S_FETCH;
              end
            end
            OP_LOOP: begin
              state <= S_FETCH;
              if (cnt == '0) begin
                pc <= endaddr + ADDR_W'(1);
              end else if (endaddr == pc + ADDR_W'(2)) begin
                reps  <= cnt;
                rskip <= 1'b1;
                pc    <= pc + ADDR_W'(1);
              end else if (sp == SP_W'(DEPTH)) begin
                err   <= 1'b1;
                sp    <= '0;
                state <= S_IDLE;
              end else begin
                st_beg[sp[ST_W-1:0]] <= pc + ADDR_W'(1);
                st_cnt[sp[ST_W-1:0]] <= cnt;
                sp <= sp + 1'b1;
                pc <= pc + ADDR_W'(1);
              end
            end
            OP_ENDL: begin
              state <= S_FETCH;
              if (sp != '0 && st_cnt[top] > 1) begin
                st_cnt[top] <= st_cnt[top] - 1'b1;
                pc <= st_beg[top];
              end else begin
                if (sp != '0) sp <= sp - 1'b1;
                pc <= pc + ADDR_W'(1);
              end
            end
            OP_TBL: begin
              tbl_sel <= mem_data[TBL_W-1:0];
              pc      <= pc + ADDR_W'(1);
              state   <= S_FETCH;
            end
            OP_STOP: begin
              sp <= '0;
              if (pidx == pat_last) begin
                done  <= 1'b1;
                state <= S_IDLE;
              end else begin
                pidx  <= nidx;
                pc    <= pat_base[nidx*ADDR_W +: ADDR_W];
                state <= S_FETCH;
              end
            end
            default: begin
              pc    <= pc + ADDR_W'(1);
              state <= S_FETCH;
            end
          endcase
        end
        S_REP: begin
          vec_stb <= 1'b1;
          if (reps > 1) begin
            reps <= reps - 1'b1;
          end else begin
            pc    <= vec_nxt;
            reps  <= '0;
            rskip <= 1'b0;
            state <= lab ? S_HALT : S_FETCH;
          end
        end
        S_HALT: if (resume) state <= S_FETCH;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_HALT_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    measure_req && $past(measure_req) |-> !vec_stb); // R6
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    measure_req && $past(measure_req) |-> $stable(pin_wfc) && $stable(tbl_sel)); // R6
  AST_REPEAT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    vec_stb && $past(vec_stb) |-> $stable(pin_wfc) && !$past(mem_rd)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !done); // R8
endmodule

// File: tb/test_vec_seq.sv
module test_vec_seq;
  localparam int NPINS = 8, WFC_W = 4, ADDR_W = 8, CNT_W = 8, DEPTH = 4, NPAT = 4, TBL_W = 2;
  localparam int PW = NPINS * WFC_W;
  localparam int IW = PW + 3;
  localparam int PI_W = $clog2(NPAT);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic resume = 1'b0;
  logic [PI_W-1:0] pat_last = '0;
  logic [NPAT*ADDR_W-1:0] pat_base = '0;
  logic mem_rd, vec_stb, measure_req, busy, done, err;
  logic [ADDR_W-1:0] mem_addr;
  logic [IW-1:0] mem_data;
  logic [PW-1:0] pin_wfc;
  logic [TBL_W-1:0] tbl_sel;

  logic [IW-1:0] mem [256];
  int nchk = 0, nerr = 0;
  int exp_pins [4096];
  int exp_tbl [4096];
  bit exp_lab [4096];
  int n_exp, idx, done_cnt;
  bit exp_err, mon_en = 1'b0;
  bit prev_stb, prev_rd, prev_meas;
  logic [PW-1:0] prev_pins;

  always #10 clk = ~clk;

  always_ff @(posedge clk) if (mem_rd) mem_data <= mem[mem_addr];

  vec_seq i_vec_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_last(pat_last), .pat_base(pat_base),
    .resume(resume), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
    .pin_wfc(pin_wfc), .vec_stb(vec_stb), .tbl_sel(tbl_sel), .measure_req(measure_req),
    .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] w_vec(input bit l, input logic [PW-1:0] p);
    return {l ? 3'd1 : 3'd0, p};
  endfunction
  function automatic logic [IW-1:0] w_loop(input int e, input int c);
    return {3'd2, {(PW-ADDR_W-CNT_W){1'b0}}, ADDR_W'(e), CNT_W'(c)};
  endfunction
  function automatic logic [IW-1:0] w_op(input logic [2:0] o, input int arg);
    return {o, PW'(arg)};
  endfunction

  function automatic int base_of(input int i);
    return int'(pat_base[i*ADDR_W +: ADDR_W]);
  endfunction

  task automatic ref_run();
    int pc, pidx, sp, tbl, reps;
    int sbeg [DEPTH];
    int scnt [DEPTH];
    bit rskip;
    logic [IW-1:0] w;
    int op, c, e;
    n_exp = 0; exp_err = 0; pidx = 0; sp = 0; tbl = 0; reps = 0; rskip = 0;
    pc = base_of(0);
    for (int g = 0; g < 5000; g++) begin
      w = mem[pc & 255];
      op = int'(w[IW-1 -: 3]);
      c = int'(w[CNT_W-1:0]);
      e = int'(w[CNT_W +: ADDR_W]);
      if (op == 0 || op == 1) begin
        int n;
        n = (reps > 0) ? reps : 1;
        for (int k = 0; k < n; k++) begin
          exp_pins[n_exp] = int'(w[PW-1:0]);
          exp_tbl[n_exp] = tbl;
          exp_lab[n_exp] = (op == 1) && (k == n - 1);
          n_exp++;
        end
        pc = (pc + (rskip ? 2 : 1)) & 255;
        reps = 0; rskip = 0;
      end else if (op == 2) begin
        if (c == 0) pc = (e + 1) & 255;
        else if (e == ((pc + 2) & 255)) begin reps = c; rskip = 1; pc = (pc + 1) & 255; end
        else if (sp == DEPTH) begin exp_err = 1; break; end
        else begin sbeg[sp] = (pc + 1) & 255; scnt[sp] = c; sp++; pc = (pc + 1) & 255; end
      end else if (op == 3) begin
        if (sp > 0 && scnt[sp-1] > 1) begin scnt[sp-1]--; pc = sbeg[sp-1]; end
        else begin if (sp > 0) sp--; pc = (pc + 1) & 255; end
      end else if (op == 4) begin
        tbl = int'(w[TBL_W-1:0]); pc = (pc + 1) & 255;
      end else if (op == 5) begin
        sp = 0;
        if (pidx == int'(pat_last)) break;
        pidx++; pc = base_of(pidx);
      end else pc = (pc + 1) & 255;
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (vec_stb) begin
        if (idx < n_exp) begin
          chk(pin_wfc == PW'(exp_pins[idx]), "R2 vector characters", pin_wfc, exp_pins[idx]);
          chk(tbl_sel == TBL_W'(exp_tbl[idx]), "R7 table for vector", tbl_sel, exp_tbl[idx]);
          chk(measure_req == exp_lab[idx], "R6 halt after labelled vector", measure_req, exp_lab[idx]);
        end else chk(1'b0, "R2 extra vector", idx, n_exp);
        if (prev_stb) chk(!prev_rd, "R3 repeat without read", prev_rd, 0);
        idx++;
      end
      if (measure_req && prev_meas)
        chk(!vec_stb && pin_wfc == prev_pins, "R6 frozen while halted", pin_wfc, prev_pins);
      if (done) done_cnt++;
    end
    prev_stb = vec_stb; prev_rd = mem_rd; prev_meas = measure_req; prev_pins = pin_wfc;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (measure_req) begin
        repeat ($urandom % 4) @(negedge clk);
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
      end
    end
  end

  task automatic run_burst(input string tag);
    int t;
    ref_run();
    idx = 0; done_cnt = 0; mon_en = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(mem_rd && mem_addr == ADDR_W'(base_of(0)) && !err, "R10 first read after start", mem_addr, base_of(0));
    t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    chk(t < 20000, {tag, " burst finished"}, t, 20000);
    repeat (2) @(negedge clk);
    mon_en = 1'b0;
    chk(idx == n_exp, {tag, " vector count"}, idx, n_exp);
    chk(done_cnt == (exp_err ? 0 : 1), "R9 done pulses", done_cnt, exp_err ? 0 : 1);
    chk(err == exp_err, "R8 error flag", err, exp_err);
    chk(!busy, "R9 idle after burst", busy, 0);
  endtask

  task automatic gen_pat(inout int a);
    int n, c, b;
    n = 4 + int'($urandom % 5);
    for (int i = 0; i < n; i++) begin
      case ($urandom % 6)
        0, 1: begin mem[a] = w_vec(0, PW'($urandom)); a++; end
        2: begin
          if ($urandom % 2 == 0) mem[a] = w_vec(1, PW'($urandom));
          else mem[a] = w_op(3'd4, int'($urandom % 4));
          a++;
        end
        3: begin
          c = int'($urandom % 5);
          mem[a] = w_loop(a + 2, c);
          mem[a+1] = w_vec($urandom % 4 == 0, PW'($urandom));
          mem[a+2] = w_op(3'd3, 0);
          a += 3;
        end
        4: begin
          c = int'($urandom % 4); b = 2 + int'($urandom % 2);
          mem[a] = w_loop(a + b + 1, c);
          for (int k = 1; k <= b; k++) mem[a+k] = w_vec(0, PW'($urandom));
          mem[a+b+1] = w_op(3'd3, 0);
          a += b + 2;
        end
        default: begin
          mem[a] = w_loop(a + 7, 1 + int'($urandom % 2));
          mem[a+1] = w_vec(0, PW'($urandom));
          mem[a+2] = w_loop(a + 5, int'($urandom % 3));
          mem[a+3] = w_vec(0, PW'($urandom));
          mem[a+4] = w_vec(0, PW'($urandom));
          mem[a+5] = w_op(3'd3, 0);
          mem[a+6] = w_op(3'd4, int'($urandom % 4));
          mem[a+7] = w_op(3'd3, 0);
          a += 8;
        end
      endcase
    end
    mem[a] = w_op(3'd5, 0);
    a++;
  endtask

  initial begin
    int a;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = w_op(3'd5, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !vec_stb && !measure_req && !done && !err && !mem_rd && pin_wfc == '0 && tbl_sel == '0,
        "R1 reset state", {busy, vec_stb, measure_req, done, err, mem_rd}, 0);

    // R4 R5 R6 R7: table select, zero-count loop, labelled repeat, plain loop
    mem[0] = w_op(3'd4, 1);
    mem[1] = w_loop(4, 0);
    mem[2] = w_vec(0, 32'h11111111);
    mem[3] = w_vec(0, 32'h22222222);
    mem[4] = w_op(3'd3, 0);
    mem[5] = w_loop(7, 3);
    mem[6] = w_vec(1, 32'hA5A5A5A5);
    mem[7] = w_op(3'd3, 0);
    mem[8] = w_op(3'd4, 3);
    mem[9] = w_loop(12, 2);
    mem[10] = w_vec(0, 32'h0F0F0F0F);
    mem[11] = w_vec(1, 32'hF0F0F0F0);
    mem[12] = w_op(3'd3, 0);
    mem[13] = w_op(3'd5, 0);
    pat_base = '0; pat_last = '0;
    run_burst("R4 R5");

    // R8: four-deep nesting works
    mem[0] = w_loop(9, 2); mem[1] = w_loop(8, 2); mem[2] = w_loop(7, 2); mem[3] = w_loop(6, 2);
    mem[4] = w_vec(0, 32'h01234567); mem[5] = w_vec(0, 32'h89ABCDEF);
    for (int k = 6; k <= 9; k++) mem[k] = w_op(3'd3, 0);
    mem[10] = w_op(3'd5, 0);
    run_burst("R8 depth limit");

    // R8: a fifth level overflows
    mem[0] = w_loop(11, 2); mem[1] = w_loop(10, 2); mem[2] = w_loop(9, 2);
    mem[3] = w_loop(8, 2); mem[4] = w_loop(7, 2);
    mem[5] = w_vec(0, 32'h55555555); mem[6] = w_vec(0, 32'h66666666);
    for (int k = 7; k <= 11; k++) mem[k] = w_op(3'd3, 0);
    mem[12] = w_op(3'd5, 0);
    run_burst("R8 overflow");

    // R10: a new start clears the error
    mem[0] = w_vec(0, 32'hCAFEF00D); mem[1] = w_op(3'd5, 0);
    run_burst("R10 restart");

    // R9: burst of three patterns, list order differs from address order
    mem[40] = w_vec(0, 32'h00000040); mem[41] = w_op(3'd5, 0);
    mem[20] = w_op(3'd4, 2); mem[21] = w_vec(0, 32'h00000020); mem[22] = w_op(3'd5, 0);
    mem[60] = w_vec(1, 32'h00000060); mem[61] = w_op(3'd5, 0);
    pat_base = {8'd0, 8'd60, 8'd20, 8'd40}; pat_last = 2'd2;
    run_burst("R9 burst");

    // R2 R3: random programs
    for (int r = 0; r < 8; r++) begin
      int b0, b1, b2;
      for (int i = 0; i < 256; i++) mem[i] = w_op(3'd5, 0);
      a = 0;
      b0 = a; gen_pat(a);
      b1 = a; gen_pat(a);
      b2 = a; gen_pat(a);
      pat_base = {8'd0, ADDR_W'(b2), ADDR_W'(b1), ADDR_W'(b0)};
      pat_last = PI_W'($urandom % 3);
      run_burst("R2 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule